// File: doc/BRIEF.md
# Feedback Divider and Phase Comparator for a Secondary PLL

This block holds the digital side of a secondary phase-locked loop. The local oscillator reaches it as `lo_tick`, a one-clock pulse for each oscillator cycle. A toggle stage halves that rate. A programmable counter then divides the halved rate by a setting in the range 272 to 8191. The full ratio from oscillator to feedback is therefore twice the setting. Each time the counter completes a period it emits a one-cycle feedback pulse.

A two-flag phase/frequency comparator measures that feedback pulse against a reference pulse train. Its result is a three-state command: drive high, drive low, or release (`pd_oe` low). An external charge pump and loop filter turn this command into the oscillator's control voltage.

An enable input stops the oscillator path. While it is low, the toggle stage is held low, the counter is cleared and oscillator ticks have no effect. Divisor changes made while the loop runs are held back until the current period completes, so no short or long feedback period is ever produced.

Top module: `swallow_div_pfd`

## Requirements
- R1: While reset is applied, and for as long as it takes to leave reset, `pre_q`, `fb_pulse` and `pd_oe` are 0.
- R2: While `div_en` is 1, `pre_q` inverts on every accepted `lo_tick`. It is 1 after an odd number of ticks counted from the start of the current feedback period.
- R3: While enabled with an active divisor N, `fb_pulse` is 1 for exactly one cycle after every 2·N ticks. That cycle is the one that follows the clock edge sampling the 2·N-th tick. `fb_pulse` is 0 at all other times.
- R4: `div_set` values from 272 to 8191 are used as given. Any value below 272 acts as 272, giving 544 ticks per feedback pulse.
- R5: A `div_set` change made while the divider runs takes effect only from the period that begins after the next feedback pulse. The period in progress keeps its old length.
- R6: While `div_en` is 0, ticks are ignored: `pre_q` and `fb_pulse` stay 0. The counter is cleared, and the setting present when enable returns is used for the first period, which lasts 2·N ticks counted from re-enable.
- R7: A feedback pulse with no reference pending makes the comparator drive high (`pd_oe`=1, `pd_level`=1) from the next cycle until a reference pulse arrives.
- R8: A reference pulse with no feedback pending makes the comparator drive low (`pd_oe`=1, `pd_level`=0) from the next cycle until a feedback pulse arrives.
- R9: A pulse on the opposite input ends the pending state, and `pd_oe` returns to 0 in the following cycle. Pulses on both inputs in the same cycle leave `pd_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lo_tick | input | 1 | One-cycle pulse per local oscillator cycle |
| div_en | input | 1 | 1 runs the oscillator path, 0 stops it |
| div_set | input | 13 | Counter divisor setting, floor 272 |
| ref_tick | input | 1 | One-cycle reference pulse |
| pre_q | output | 1 | State of the halving stage |
| fb_pulse | output | 1 | One-cycle feedback pulse at terminal count |
| pd_level | output | 1 | Comparator drive level, valid while pd_oe is 1 |
| pd_oe | output | 1 | Comparator drive enable; 0 means released (high impedance) |

## Verification
The assertions assume that `lo_tick` and `ref_tick` are single-cycle pulses synchronous to `clk`. They also assume that `div_set` and `div_en` change only between clock edges, as register outputs would. The bench keeps to these assumptions: it changes every input just after a falling edge, holds each pulse for exactly one cycle, and changes the divisor both at period boundaries and partway through a period. Ticks are sent back to back, which is the fastest legal rate and still keeps feedback pulses at least 544 cycles apart.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  localparam int unsigned SDP_DIV_W   = 13;
  localparam int unsigned SDP_MIN_DIV = 272;

  typedef enum logic [1:0] {
    PD_RELEASE = 2'd0,
    PD_PUMP_UP = 2'd1,
    PD_PUMP_DN = 2'd2
  } pd_cmd_e;

endpackage

// File: rtl/sdp_prescaler.sv
module sdp_prescaler (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lo_tick,
  output logic tog_q,
  output logic pre_pulse
);

  logic tog_d;

  always_comb begin
    tog_d = tog_q;
    if (!en) begin
      tog_d = 1'b0;
    end else if (lo_tick) begin
      tog_d = ~tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
    end else begin
      tog_q <= tog_d;
    end
  end

  assign pre_pulse = en & lo_tick & tog_q;

  // R2: each accepted tick flips the stage
  p_tick_flips_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lo_tick) |=> (tog_q != $past(tog_q)));

  // R6: stage is held low while stopped
  p_stop_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tog_q);

endmodule

// File: rtl/sdp_divider.sv
module sdp_divider #(
  parameter int unsigned DIV_W   = sdp_pkg::SDP_DIV_W,
  parameter int unsigned MIN_DIV = sdp_pkg::SDP_MIN_DIV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pre_pulse,
  input  logic [DIV_W-1:0] div_set,
  output logic             fb_pulse
);

  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] n_q, n_d;
  logic [DIV_W-1:0] set_floor;
  logic             fb_q, fb_d;
  logic             at_tc;

  assign set_floor = (div_set < MIN_V) ? MIN_V : div_set;
  assign at_tc     = (cnt_q == (n_q - 1'b1));

  always_comb begin
    cnt_d = cnt_q;
    n_d   = n_q;
    fb_d  = 1'b0;
    if (!en) begin
      cnt_d = '0;
      n_d   = set_floor;
    end else if (pre_pulse) begin
      if (at_tc) begin
        cnt_d = '0;
        n_d   = set_floor;
        fb_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      n_q   <= MIN_V;
      fb_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      n_q   <= n_d;
      fb_q  <= fb_d;
    end
  end

  assign fb_pulse = fb_q;

  // R3: count stays inside the active period
  p_cnt_in_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < n_q);

  // R3: feedback pulse lasts a single cycle
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fb_q |=> !fb_q);

  // R4: active divisor never below the floor
  p_div_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    n_q >= MIN_V);

  // R5: divisor is frozen mid-period while running
  p_div_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(pre_pulse && at_tc)) |=> $stable(n_q));

  // R6: no feedback pulse follows a stopped cycle
  p_no_pulse_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !fb_q);

endmodule

// File: rtl/sdp_pfd.sv
module sdp_pfd (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_pulse,
  input  logic ref_tick,
  output logic pd_level,
  output logic pd_oe
);

  import sdp_pkg::*;

  logic    up_q, up_d;
  logic    dn_q, dn_d;
  logic    up_set, dn_set;
  pd_cmd_e cmd;

  assign up_set = up_q | fb_pulse;
  assign dn_set = dn_q | ref_tick;

  always_comb begin
    up_d = up_set;
    dn_d = dn_set;
    if (up_set && dn_set) begin
      up_d = 1'b0;
      dn_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  always_comb begin
    if (up_q)      cmd = PD_PUMP_UP;
    else if (dn_q) cmd = PD_PUMP_DN;
    else           cmd = PD_RELEASE;
  end

  assign pd_oe    = (cmd != PD_RELEASE);
  assign pd_level = (cmd == PD_PUMP_UP);

  // R9: both flags are never pending together
  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_q && dn_q));

  // R7: lone feedback pulse leads to a high drive
  p_lead_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_pulse && !ref_tick && !dn_q) |=> (pd_oe && pd_level));

  // R8: lone reference pulse leads to a low drive
  p_lag_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && !fb_pulse && !up_q) |=> (pd_oe && !pd_level));

  // R9: coincident pulses with nothing pending leave the output released
  p_coincide_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && fb_pulse && !up_q && !dn_q) |=> !pd_oe);

endmodule

// File: rtl/swallow_div_pfd.sv
module swallow_div_pfd #(
  parameter int unsigned DIV_W   = sdp_pkg::SDP_DIV_W,
  parameter int unsigned MIN_DIV = sdp_pkg::SDP_MIN_DIV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_tick,
  input  logic             div_en,
  input  logic [DIV_W-1:0] div_set,
  input  logic             ref_tick,
  output logic             pre_q,
  output logic             fb_pulse,
  output logic             pd_level,
  output logic             pd_oe
);

  localparam int unsigned SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;
  logic              pre_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[SYNC_N-1];

  sdp_prescaler u_pre (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (div_en),
    .lo_tick   (lo_tick),
    .tog_q     (pre_q),
    .pre_pulse (pre_pulse)
  );

  sdp_divider #(
    .DIV_W   (DIV_W),
    .MIN_DIV (MIN_DIV)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (div_en),
    .pre_pulse (pre_pulse),
    .div_set   (div_set),
    .fb_pulse  (fb_pulse)
  );

  sdp_pfd u_pfd (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fb_pulse (fb_pulse),
    .ref_tick (ref_tick),
    .pd_level (pd_level),
    .pd_oe    (pd_oe)
  );

  // R1: outputs quiet while internal reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_int_n |-> (!pre_q && !fb_pulse && !pd_oe));

endmodule

// File: tb/swallow_div_pfd_bench.sv
module swallow_div_pfd_bench;

  logic        clk;
  logic        rst_n;
  logic        lo_tick;
  logic        div_en;
  logic [12:0] div_set;
  logic        ref_tick;
  logic        pre_q;
  logic        fb_pulse;
  logic        pd_level;
  logic        pd_oe;

  int n_checks;
  int n_fail;
  int cyc;
  int k_ticks;
  int n_cur;
  bit done;

  swallow_div_pfd u_swallow_div_pfd (
    .clk      (clk),
    .rst_n    (rst_n),
    .lo_tick  (lo_tick),
    .div_en   (div_en),
    .div_set  (div_set),
    .ref_tick (ref_tick),
    .pre_q    (pre_q),
    .fb_pulse (fb_pulse),
    .pd_level (pd_level),
    .pd_oe    (pd_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    cyc = 0;
    wait (cyc > 200000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 200000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  function automatic int floor_div(int v);
    return (v < 272) ? 272 : v;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (tick %0d, N %0d)", tag, act, exp, k_ticks, n_cur);
    end
  endtask

  // one oscillator tick, then compare against the arithmetic model
  task automatic tick(string tag);
    logic exp_fb;
    lo_tick = 1'b1;
    @(negedge clk);
    lo_tick = 1'b0;
    exp_fb = 1'b0;
    if (div_en) begin
      k_ticks++;
      if (k_ticks == 2 * n_cur) begin
        exp_fb  = 1'b1;
        k_ticks = 0;
        n_cur   = floor_div(int'(div_set));
      end
    end
    chk({tag, " fb_pulse"}, fb_pulse, exp_fb);
    chk({"R2 ", tag, " pre_q"}, pre_q, div_en ? logic'(k_ticks % 2) : 1'b0);
  endtask

  task automatic run(string tag, int n);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic set_enable(logic v);
    div_en = v;
    @(negedge clk);
    if (!v) k_ticks = 0;
  endtask

  task automatic start_with(int setting);
    set_enable(1'b0);
    div_set = 13'(setting);
    @(negedge clk);
    n_cur   = floor_div(setting);
    k_ticks = 0;
    set_enable(1'b1);
  endtask

  task automatic pulse_ref;
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 0;
    rst_n    = 1'b0;
    lo_tick  = 1'b0;
    div_en   = 1'b0;
    div_set  = 13'd272;
    ref_tick = 1'b0;
    k_ticks  = 0;
    n_cur    = 272;

    repeat (3) @(negedge clk);
    chk("R1 pre_q in reset", pre_q, 1'b0);
    chk("R1 fb_pulse in reset", fb_pulse, 1'b0);
    chk("R1 pd_oe in reset", pd_oe, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 pd_oe after reset", pd_oe, 1'b0);
    chk("R1 fb_pulse after reset", fb_pulse, 1'b0);

    // R3: periods at the floor and just above it
    start_with(272);
    run("R3 N=272", 2 * 544);
    start_with(273);
    run("R3 N=273", 2 * 546);
    start_with(300);
    run("R3 N=300", 600);

    // R5: change partway through a period
    start_with(273);
    run("R5 before change", 100);
    div_set = 13'd300;
    run("R5 old period", 446);
    chk("R5 next length", logic'(n_cur == 300), 1'b1);
    run("R5 new periods", 1200);
    div_set = 13'd272;
    run("R5 back to floor", 600 + 544);

    // R4: settings below the floor, and the top of the range
    start_with(5);
    run("R4 set=5", 2 * 544);
    start_with(0);
    run("R4 set=0", 544);
    start_with(271);
    run("R4 set=271", 544);
    start_with(8191);
    run("R4 set=8191", 2 * 8191);

    // R6: stop partway, ticks ignored, restart counts from zero
    start_with(280);
    run("R6 running", 300);
    set_enable(1'b0);
    run("R6 stopped", 700);
    div_set = 13'd290;
    @(negedge clk);
    n_cur = 290;
    set_enable(1'b1);
    run("R6 restarted", 2 * 580);

    // comparator: idle the oscillator path and clear any pending state
    set_enable(1'b0);
    if (pd_oe && pd_level) pulse_ref;
    @(negedge clk);
    chk("R9 idle released", pd_oe, 1'b0);

    pulse_ref;
    chk("R8 ref alone oe", pd_oe, 1'b1);
    chk("R8 ref alone level", pd_level, 1'b0);
    repeat (5) @(negedge clk);
    chk("R8 low held", pd_oe && !pd_level, 1'b1);

    start_with(272);
    run("R3 pfd feed", 543);
    tick("R3 pfd feed");
    chk("R8 still low at fb cycle", pd_oe && !pd_level, 1'b1);
    @(negedge clk);
    chk("R9 fb clears low", pd_oe, 1'b0);

    run("R3 pfd lead", 543);
    tick("R3 pfd lead");
    @(negedge clk);
    chk("R7 fb alone oe", pd_oe, 1'b1);
    chk("R7 fb alone level", pd_level, 1'b1);
    repeat (4) @(negedge clk);
    chk("R7 high held", pd_oe && pd_level, 1'b1);
    pulse_ref;
    chk("R9 ref clears high", pd_oe, 1'b0);

    run("R3 pfd both", 543);
    tick("R3 pfd both");
    pulse_ref;
    chk("R9 coincident stays released", pd_oe, 1'b0);
    @(negedge clk);
    chk("R9 coincident later", pd_oe, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule